// File: doc/BRIEF.md
# E1 Timeslot-Zero Transmit Generator

This block builds the eight bits of timeslot zero for every frame of a 30-channel E1 PCM stream across a 16-frame CRC-4 multiframe. A frame strobe steps an internal frame index. Even frames carry the alignment word: the CRC-4 bit for that frame followed by a fixed seven-bit pattern. Odd frames carry the non-alignment word: a position-dependent first bit (the multiframe alignment sequence or an E-bit), a constant one, the remote alarm bit and five national bits.

The national bits come from a five-byte buffer. Each byte stores one national bit position for all eight odd frames of the multiframe. Software-side writes land in a shadow copy, and the transmitted copy reloads only when the multiframe restarts, so one multiframe never mixes old and new content. A data-link select takes the national bits from a live input instead of the buffer. A transmit-AIS input forces the whole byte to all ones at any time, including straight after reset.

The sequencer is a three-state machine. ST_IDLE is entered on reset; it shows all ones and waits for the first strobe. ST_FAS is an even frame and ST_NFAS is an odd frame. The transitions are IDLE_TO_FAS (first strobe, index set to 0 and buffer loaded), FAS_TO_NFAS (strobe, index plus one) and NFAS_TO_FAS (strobe, index plus one, wrapping 15 to 0 with a buffer load). Without a strobe the state is held.

Top module: `e1_ts0_gen`

## Requirements
- R1: After reset the block is in ST_IDLE, `ts0_byte` is 8'hFF and `frame_idx` is 15, until the first `frame_strb`. The first strobe moves to frame 0.
- R2: Each `frame_strb` cycle advances `frame_idx` by one and wraps it from 15 to 0. Without a strobe, `frame_idx` and the word type hold.
- R3: In even frames, `ts0_byte` is {Cn, 7'b0011011}, with `ts0_byte[7]` as bit 1 (sent first). Cn is `crc_bits[0]` (C1) in frames 0 and 8, `crc_bits[1]` (C2) in frames 2 and 10, `crc_bits[2]` (C3) in frames 4 and 12, and `crc_bits[3]` (C4) in frames 6 and 14.
- R4: In odd frames, `ts0_byte[6]` is 1, `ts0_byte[5]` is `alarm_a`, and `ts0_byte[4:0]` are Sa4, Sa5, Sa6, Sa7, Sa8 from bit 4 down to bit 0.
- R5: `ts0_byte[7]` in odd frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 respectively.
- R6: `ts0_byte[7]` is `e_bits[0]` in frame 13 and `e_bits[1]` in frame 15.
- R7: Buffer address 0 to 4 holds Sa4 to Sa8. In each byte, bit 7 is frame 1, bit 6 is frame 3, and so on down to bit 0 for frame 15. Writes to addresses 5 to 7 have no effect.
- R8: A buffer write reaches the output only from the next entry into frame 0. The frames of the multiframe that is running keep the earlier content.
- R9: While `dl_sel` is 1, the national bits come from `dl_sa` (bit 4 is Sa4, bit 0 is Sa8) instead of the buffer.
- R10: While `ais_force` is 1, `ts0_byte` is 8'hFF in the same cycle, while the frame index keeps counting. Releasing it restores the normal word for the current frame.
- R11: After reset, every buffer byte reads as all ones at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strb | input | 1 | One-cycle pulse that starts the next frame |
| crc_bits | input | 4 | CRC-4 bits C1..C4 at bits 0..3 |
| e_bits | input | 2 | E1 at bit 0, E2 at bit 1 |
| alarm_a | input | 1 | Remote alarm bit |
| dl_sel | input | 1 | Take national bits from `dl_sa` |
| dl_sa | input | 5 | Data-link national bits, Sa4 at bit 4 |
| ais_force | input | 1 | Force all-ones output |
| nbb_we | input | 1 | Buffer write enable |
| nbb_addr | input | 3 | Buffer byte address |
| nbb_wdata | input | 8 | Buffer write data |
| ts0_byte | output | 8 | Timeslot-zero byte, bit 7 sent first |
| frame_idx | output | 4 | Current frame number in the multiframe |

## Verification
The hardest case to reach is the deferred buffer load. A write must stay invisible for the rest of a running multiframe and then appear exactly at frame 0. The bench writes new buffer content in the middle of a multiframe. It checks the remaining odd frames against the old content, then walks through the wrap and checks every odd frame against the new content. It also overlays the data-link and AIS overrides on a running multiframe, so the frame index is seen to keep counting underneath them.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
    localparam int MF_FRAMES = 16;
    localparam int FRM_W     = $clog2(MF_FRAMES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FAS  = 2'd1,
        ST_NFAS = 2'd2
    } ts0_state_e;

    localparam logic [6:0] ALIGN_PAT = 7'b0011011;
    localparam logic [5:0] MF_SEQ    = 6'b001011;
endpackage

// File: rtl/e1_ts0_seq.sv
module e1_ts0_seq
    import e1_ts0_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strb_i,
    output ts0_state_e       state_o,
    output logic [FRM_W-1:0] frm_o,
    output logic             mf_load_o
);
    localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(MF_FRAMES - 1);

    ts0_state_e       state_q, state_d;
    logic [FRM_W-1:0] frm_q, frm_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frm_q   <= LAST_FRM;
        end else begin
            state_q <= state_d;
            frm_q   <= frm_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        frm_d     = frm_q;
        mf_load_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (strb_i) begin
                    state_d   = ST_FAS;
                    frm_d     = '0;
                    mf_load_o = 1'b1;
                end
            end
            ST_FAS: begin
                if (strb_i) begin
                    state_d = ST_NFAS;
                    frm_d   = frm_q + 1'b1;
                end
            end
            ST_NFAS: begin
                if (strb_i) begin
                    state_d = ST_FAS;
                    if (frm_q == LAST_FRM) begin
                        frm_d     = '0;
                        mf_load_o = 1'b1;
                    end else begin
                        frm_d = frm_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state_o = state_q;
    assign frm_o   = frm_q;

    // R3: alignment word only on even frame numbers
    p_fas_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAS) |-> (frm_q[0] == 1'b0));

    // R2: wrap from last frame to frame 0
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_i && state_q == ST_NFAS && frm_q == LAST_FRM) |=> (frm_q == '0));

    // R2: hold without strobe
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_i |=> ($stable(frm_q) && $stable(state_q)));

    // R1: first strobe after reset lands on frame 0
    p_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_i && state_q == ST_IDLE) |=> (frm_q == '0 && state_q == ST_FAS));
endmodule

// File: rtl/e1_ts0_natbuf.sv
module e1_ts0_natbuf #(
    parameter int SA_BYTES = 5,
    parameter int BYTE_W   = 8,
    parameter int ADDR_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BYTE_W-1:0]           wdata_i,
    input  logic                        load_i,
    input  logic [$clog2(BYTE_W)-1:0]   slot_i,
    output logic [SA_BYTES-1:0]         sa_o
);
    localparam int SLOT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shadow_q [SA_BYTES];
    logic [BYTE_W-1:0] active_q [SA_BYTES];
    logic [SA_BYTES*BYTE_W-1:0] active_flat;

    for (genvar gi = 0; gi < SA_BYTES; gi++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[gi] <= '1;
            end else if (we_i && (addr_i == ADDR_W'(gi))) begin
                shadow_q[gi] <= wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q[gi] <= '1;
            end else if (load_i) begin
                active_q[gi] <= shadow_q[gi];
            end
        end

        assign sa_o[SA_BYTES-1-gi] = active_q[gi][SLOT_W'(BYTE_W-1) - slot_i];
        assign active_flat[gi*BYTE_W +: BYTE_W] = active_q[gi];
    end

    // R8: transmitted copy changes only at a multiframe start
    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(active_flat));
endmodule

// File: rtl/e1_ts0_compose.sv
module e1_ts0_compose
    import e1_ts0_pkg::*;
#(
    parameter int SA_BYTES = 5
) (
    input  ts0_state_e          state_i,
    input  logic [FRM_W-1:0]    frm_i,
    input  logic [3:0]          crc_i,
    input  logic [1:0]          e_i,
    input  logic                alarm_i,
    input  logic [SA_BYTES-1:0] buf_sa_i,
    input  logic                dl_sel_i,
    input  logic [SA_BYTES-1:0] dl_sa_i,
    input  logic                ais_i,
    output logic [7:0]          byte_o
);
    logic [2:0]          slot;
    logic                lead_bit;
    logic [SA_BYTES-1:0] sa_sel;

    assign slot   = frm_i[3:1];
    assign sa_sel = dl_sel_i ? dl_sa_i : buf_sa_i;

    always_comb begin
        if (slot < 3'd6) begin
            lead_bit = MF_SEQ[3'd5 - slot];
        end else if (slot == 3'd6) begin
            lead_bit = e_i[0];
        end else begin
            lead_bit = e_i[1];
        end
    end

    always_comb begin
        byte_o = 8'hFF;
        if (!ais_i) begin
            unique case (state_i)
                ST_IDLE: byte_o = 8'hFF;
                ST_FAS:  byte_o = {crc_i[frm_i[2:1]], ALIGN_PAT};
                ST_NFAS: byte_o = {lead_bit, 1'b1, alarm_i, sa_sel};
                default: byte_o = 8'hFF;
            endcase
        end
    end
endmodule

// File: rtl/e1_ts0_gen.sv
module e1_ts0_gen
    import e1_ts0_pkg::*;
#(
    parameter int SA_BYTES = 5,
    parameter int BYTE_W   = 8,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strb,
    input  logic [3:0]        crc_bits,
    input  logic [1:0]        e_bits,
    input  logic              alarm_a,
    input  logic              dl_sel,
    input  logic [4:0]        dl_sa,
    input  logic              ais_force,
    input  logic              nbb_we,
    input  logic [2:0]        nbb_addr,
    input  logic [7:0]        nbb_wdata,
    output logic [7:0]        ts0_byte,
    output logic [3:0]        frame_idx
);
    ts0_state_e          state;
    logic [FRM_W-1:0]    frm;
    logic                mf_load;
    logic [SA_BYTES-1:0] buf_sa;

    e1_ts0_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_i    (frame_strb),
        .state_o   (state),
        .frm_o     (frm),
        .mf_load_o (mf_load)
    );

    e1_ts0_natbuf #(
        .SA_BYTES (SA_BYTES),
        .BYTE_W   (BYTE_W),
        .ADDR_W   (ADDR_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (nbb_we),
        .addr_i  (nbb_addr),
        .wdata_i (nbb_wdata),
        .load_i  (mf_load),
        .slot_i  (frm[3:1]),
        .sa_o    (buf_sa)
    );

    e1_ts0_compose #(
        .SA_BYTES (SA_BYTES)
    ) u_comp (
        .state_i  (state),
        .frm_i    (frm),
        .crc_i    (crc_bits),
        .e_i      (e_bits),
        .alarm_i  (alarm_a),
        .buf_sa_i (buf_sa),
        .dl_sel_i (dl_sel),
        .dl_sa_i  (dl_sa),
        .ais_i    (ais_force),
        .byte_o   (ts0_byte)
    );

    assign frame_idx = frm;

    // R10: forced all ones
    p_ais_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ais_force |-> (ts0_byte == 8'hFF));

    // R4: second bit of odd-frame word is one
    p_nfas_bit2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NFAS) |-> ts0_byte[6]);

    // R9: data-link bits appear verbatim in odd frames
    p_dl_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NFAS && dl_sel && !ais_force) |-> (ts0_byte[4:0] == dl_sa));
endmodule

// File: tb/e1_ts0_gen_tb.sv
module e1_ts0_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strb = 1'b0;
    logic [3:0] crc_bits = 4'b0000;
    logic [1:0] e_bits = 2'b00;
    logic       alarm_a = 1'b0;
    logic       dl_sel = 1'b0;
    logic [4:0] dl_sa = 5'b0;
    logic       ais_force = 1'b0;
    logic       nbb_we = 1'b0;
    logic [2:0] nbb_addr = 3'd0;
    logic [7:0] nbb_wdata = 8'd0;
    logic [7:0] ts0_byte;
    logic [3:0] frame_idx;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] sh_m  [5];
    logic [7:0] act_m [5];
    bit         started = 1'b0;
    int         fidx_m = 15;

    always #10 clk = ~clk;

    e1_ts0_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_strb (frame_strb),
        .crc_bits   (crc_bits),
        .e_bits     (e_bits),
        .alarm_a    (alarm_a),
        .dl_sel     (dl_sel),
        .dl_sa      (dl_sa),
        .ais_force  (ais_force),
        .nbb_we     (nbb_we),
        .nbb_addr   (nbb_addr),
        .nbb_wdata  (nbb_wdata),
        .ts0_byte   (ts0_byte),
        .frame_idx  (frame_idx)
    );

    function automatic logic [7:0] model_byte(int f);
        logic [7:0] r;
        int k;
        logic b1;
        logic [4:0] sa;
        if (ais_force || !started) return 8'hFF;
        if ((f % 2) == 0) begin
            r = {crc_bits[(f / 2) % 4], 7'b0011011};
        end else begin
            k = f / 2;
            if (k < 6) b1 = (k == 2 || k == 4 || k == 5);
            else if (k == 6) b1 = e_bits[0];
            else b1 = e_bits[1];
            for (int i = 0; i < 5; i++) sa[4 - i] = act_m[i][7 - k];
            if (dl_sel) sa = dl_sa;
            r = {b1, 1'b1, alarm_a, sa};
        end
        return r;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s frame %0d: actual %h expected %h", req, fidx_m, act, exp);
        end
    endtask

    task automatic check_now(string req);
        check(req, ts0_byte, model_byte(fidx_m));
        check({req, "/R2 index"}, {4'b0, frame_idx}, 8'(fidx_m));
    endtask

    task automatic step_frame(string req);
        @(negedge clk);
        frame_strb = 1'b1;
        @(negedge clk);
        frame_strb = 1'b0;
        if (!started || fidx_m == 15) begin
            for (int i = 0; i < 5; i++) act_m[i] = sh_m[i];
            fidx_m  = 0;
            started = 1'b1;
        end else begin
            fidx_m = fidx_m + 1;
        end
        #1;
        check_now(req);
    endtask

    task automatic buf_write(int a, logic [7:0] d);
        @(negedge clk);
        nbb_we = 1'b1;
        nbb_addr = 3'(a);
        nbb_wdata = d;
        @(negedge clk);
        nbb_we = 1'b0;
        if (a < 5) sh_m[a] = d;
    endtask

    task automatic t_reset;
        #1;
        check("R1 reset byte", ts0_byte, 8'hFF);
        check("R1 reset index", {4'b0, frame_idx}, 8'd15);
    endtask

    task automatic t_default_buffer;
        // R11: before any write, national bits are all ones
        crc_bits = 4'b0110; e_bits = 2'b01; alarm_a = 1'b1;
        for (int n = 0; n < 16; n++) step_frame("R11 default buffer");
    endtask

    task automatic t_full_mf;
        // R3 R4 R5 R6 R7: every frame against the written pattern
        buf_write(0, 8'hA5); buf_write(1, 8'h3C); buf_write(2, 8'h96);
        buf_write(3, 8'h0F); buf_write(4, 8'hE1);
        buf_write(6, 8'h00); // R7: ignored address
        for (int n = 0; n < 16; n++) step_frame("R3/R4/R5/R6/R7 frame");
    endtask

    task automatic t_deferred;
        // R8: mid-multiframe write stays hidden until frame 0
        crc_bits = 4'b1001; e_bits = 2'b10; alarm_a = 1'b0;
        for (int n = 0; n < 3; n++) step_frame("R8 pre-write");
        buf_write(0, 8'h00); buf_write(4, 8'h5A);
        for (int n = 0; n < 13; n++) step_frame("R8 old content");
        for (int n = 0; n < 16; n++) step_frame("R8 new content");
    endtask

    task automatic t_hold;
        // R2: no strobe keeps the frame
        repeat (6) @(negedge clk);
        #1;
        check_now("R2 hold");
    endtask

    task automatic t_dl;
        // R9
        @(negedge clk);
        dl_sel = 1'b1; dl_sa = 5'b10110;
        for (int n = 0; n < 6; n++) step_frame("R9 data link");
        dl_sa = 5'b01001;
        #1;
        check_now("R9 data link change");
        @(negedge clk);
        dl_sel = 1'b0;
        #1;
        check_now("R9 release");
    endtask

    task automatic t_ais;
        // R10
        @(negedge clk);
        ais_force = 1'b1;
        #1;
        check("R10 immediate", ts0_byte, 8'hFF);
        for (int n = 0; n < 3; n++) step_frame("R10 forced");
        @(negedge clk);
        ais_force = 1'b0;
        #1;
        check_now("R10 release");
        step_frame("R10 resumed");
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin
            sh_m[i] = 8'hFF;
            act_m[i] = 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_buffer();
        t_full_mf();
        t_deferred();
        t_hold();
        t_dl();
        t_ais();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule